// File: doc/BRIEF.md
# SD Host Interrupt Status Block

This block collects the event and error indications of an SD/MMC host controller and presents them to software as two 32-bit status words on a simple register bus. The first word carries card and transfer events (response done, data done, card inserted, card removed) plus the live card-detect level. The second word carries the command and data error flags, the read- and write-buffer-ready flags, and the live DAT0 and command-busy levels.

Each status word has a mask word beside it. A registered interrupt output is raised while any latched flag is pending with its mask bit at 0. Software acknowledges flags by writing 0 to the bits it wants cleared and 1 to the bits it wants left alone. The buffer-ready flags capture the rising edge of their condition, so software acknowledges them before it drains or fills the buffer. The card-detect pin is treated as asynchronous and passes through a two-flop synchronizer before the insert and remove edges are detected.

Top module: `sd_irq_regs`

## Requirements
- R1: After reset every latched flag reads 0, the interrupt output is 0, and both mask words read all ones on their latched positions (word 1 mask reads 0x0000001D, word 2 mask reads 0x0000837F).
- R2: A one-cycle event pulse sets its flag at the next clock edge. In word 1, bit 0 is response done and bit 2 is data done. In word 2, bit 0 is command index error, bit 1 CRC error, bit 2 end-bit error, bit 3 data timeout, bit 4 illegal write, bit 5 illegal read, bit 6 response timeout and bit 15 illegal access.
- R3: A bus write to a status word clears every latched flag whose write-data bit is 0 and leaves every flag whose write-data bit is 1 unchanged.
- R4: When a hardware event and a software clear reach the same flag in the same cycle, the flag is set.
- R5: Word 2 bit 8 (read buffer ready) is set on a 0-to-1 transition of the buffer-full input and bit 9 (write buffer ready) on a 0-to-1 transition of the buffer-empty input; once cleared they stay 0 while the input stays high.
- R6: Word 1 bit 5 shows the card-detect pin after two clock edges of synchronization; word 2 bit 7 shows the DAT0 input and bit 14 the command-busy input directly. Writes leave these bits unaffected.
- R7: A rising edge of the synchronized card-detect level sets word 1 bit 4 (inserted) and a falling edge sets bit 3 (removed), one edge after the live bit changes.
- R8: Bus word address 0 selects status word 1, 1 its mask, 2 status word 2, 3 its mask; a mask bit of 1 blocks the matching flag from the interrupt.
- R9: The interrupt output is registered and equals, one cycle later, the OR over both words of each latched flag AND NOT its mask bit; live bits never drive it.
- R10: Bit positions with no defined flag read 0 in status and mask words, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address (0 status 1, 1 mask 1, 2 status 2, 3 mask 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_resp_done | input | 1 | Response complete pulse |
| ev_data_done | input | 1 | Data transfer complete pulse |
| err_cmd_idx | input | 1 | Command index error pulse |
| err_crc | input | 1 | CRC error pulse |
| err_end_bit | input | 1 | End-bit error pulse |
| err_data_to | input | 1 | Data timeout pulse |
| err_ill_wr | input | 1 | Illegal write pulse |
| err_ill_rd | input | 1 | Illegal read pulse |
| err_rsp_to | input | 1 | Response timeout pulse |
| err_ill_acc | input | 1 | Illegal access pulse |
| rbuf_full | input | 1 | Read buffer holds a full block (level) |
| wbuf_empty | input | 1 | Write buffer can take a block (level) |
| cd_pin | input | 1 | Asynchronous card-detect level |
| dat0_in | input | 1 | DAT0 line level |
| cmd_busy_in | input | 1 | Command engine busy level |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the set-versus-clear race, where a design that let the clear win would lose a response event arriving during software's acknowledge write. It holds the buffer-full level high across a clear to catch a level-sensitive implementation, which would re-assert the ready flag at once and make software drain twice. It times the card-detect path edge by edge, so a missing synchronizer stage or an insert flag raised together with the live bit shows up as a wrong value one cycle early. It also measures the one-cycle interrupt latency and checks that a masked flag, a live bit and an unused bit position never raise the interrupt or read back as 1.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

  // Word addresses on the register bus
  localparam int unsigned WA_STS1  = 0;
  localparam int unsigned WA_MSK1  = 1;
  localparam int unsigned WA_STS2  = 2;
  localparam int unsigned WA_MSK2  = 3;

  // Word 1 bit positions
  localparam int unsigned B1_RSP   = 0;
  localparam int unsigned B1_DONE  = 2;
  localparam int unsigned B1_REM   = 3;
  localparam int unsigned B1_INS   = 4;
  localparam int unsigned B1_CDLV  = 5;

  // Word 2 bit positions
  localparam int unsigned B2_IDX   = 0;
  localparam int unsigned B2_CRC   = 1;
  localparam int unsigned B2_ENDB  = 2;
  localparam int unsigned B2_DTO   = 3;
  localparam int unsigned B2_ILW   = 4;
  localparam int unsigned B2_ILR   = 5;
  localparam int unsigned B2_RTO   = 6;
  localparam int unsigned B2_DAT0  = 7;
  localparam int unsigned B2_RBRDY = 8;
  localparam int unsigned B2_WBRDY = 9;
  localparam int unsigned B2_BUSY  = 14;
  localparam int unsigned B2_ILA   = 15;

  // Latched positions of each word (also the mask reset value)
  localparam logic [31:0] KEEP1 = (32'd1 << B1_RSP) | (32'd1 << B1_DONE) |
                                  (32'd1 << B1_REM) | (32'd1 << B1_INS);
  localparam logic [31:0] KEEP2 = (32'd1 << B2_IDX) | (32'd1 << B2_CRC) |
                                  (32'd1 << B2_ENDB) | (32'd1 << B2_DTO) |
                                  (32'd1 << B2_ILW) | (32'd1 << B2_ILR) |
                                  (32'd1 << B2_RTO) | (32'd1 << B2_RBRDY) |
                                  (32'd1 << B2_WBRDY) | (32'd1 << B2_ILA);

  // Next flag value: hardware set beats a write-zero clear
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] set,
                                            input logic        hit,
                                            input logic [31:0] wdata,
                                            input logic [31:0] keep);
    logic [31:0] clr;
    clr = hit ? ~wdata : 32'd0;
    return (set | (cur & ~clr)) & keep;
  endfunction

  // Any flag pending with its mask bit open
  function automatic logic any_open(input logic [31:0] f1, input logic [31:0] m1,
                                    input logic [31:0] f2, input logic [31:0] m2);
    return (|(f1 & ~m1)) | (|(f2 & ~m2));
  endfunction

endpackage

// File: rtl/sd_rise_catch.sv
module sd_rise_catch #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lvl_i,
  output logic [LANES-1:0] rise_o
);
  logic [LANES-1:0] prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/sd_cd_sync.sv
module sd_cd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cd_async,
  output logic cd_live,
  output logic ev_ins,
  output logic ev_rem
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], cd_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign cd_live = sync_q[STAGES-1];
  assign ev_ins  =  cd_live & ~last_q;
  assign ev_rem  = ~cd_live &  last_q;

endmodule

// File: rtl/sd_flag_bank.sv
module sd_flag_bank #(
  parameter int unsigned  DATA_W = 32,
  parameter logic [31:0]  KEEP   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] flags_o
);
  import sd_irq_pkg::*;

  logic [DATA_W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_next(flags_q, set_i, hit_i, wdata_i, KEEP);
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/sd_irq_regs.sv
module sd_irq_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CD_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_resp_done,
  input  logic              ev_data_done,
  input  logic              err_cmd_idx,
  input  logic              err_crc,
  input  logic              err_end_bit,
  input  logic              err_data_to,
  input  logic              err_ill_wr,
  input  logic              err_ill_rd,
  input  logic              err_rsp_to,
  input  logic              err_ill_acc,
  input  logic              rbuf_full,
  input  logic              wbuf_empty,
  input  logic              cd_pin,
  input  logic              dat0_in,
  input  logic              cmd_busy_in,
  output logic              irq
);
  import sd_irq_pkg::*;

  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEEP1);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEEP2);

  // Named internal events
  logic              cd_live, ev_ins, ev_rem;
  logic [1:0]        buf_lvl, buf_rise;
  logic              hit_sts1, hit_sts2, hit_msk1, hit_msk2;
  logic [DATA_W-1:0] set1, set2;
  logic [DATA_W-1:0] flags1_q, flags2_q;
  logic [DATA_W-1:0] mask1_q, mask2_q;
  logic [DATA_W-1:0] live1, live2;
  logic              irq_q;

  sd_cd_sync #(.STAGES(CD_STAGES)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cd_async(cd_pin),
    .cd_live (cd_live),
    .ev_ins  (ev_ins),
    .ev_rem  (ev_rem)
  );

  assign buf_lvl = {wbuf_empty, rbuf_full};

  sd_rise_catch #(.LANES(2)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (buf_lvl),
    .rise_o(buf_rise)
  );

  // Bus decode
  assign hit_sts1 = bus_wr && (bus_addr == ADDR_W'(WA_STS1));
  assign hit_msk1 = bus_wr && (bus_addr == ADDR_W'(WA_MSK1));
  assign hit_sts2 = bus_wr && (bus_addr == ADDR_W'(WA_STS2));
  assign hit_msk2 = bus_wr && (bus_addr == ADDR_W'(WA_MSK2));

  // Set vectors
  always_comb begin
    set1           = '0;
    set1[B1_RSP]   = ev_resp_done;
    set1[B1_DONE]  = ev_data_done;
    set1[B1_REM]   = ev_rem;
    set1[B1_INS]   = ev_ins;
  end

  always_comb begin
    set2           = '0;
    set2[B2_IDX]   = err_cmd_idx;
    set2[B2_CRC]   = err_crc;
    set2[B2_ENDB]  = err_end_bit;
    set2[B2_DTO]   = err_data_to;
    set2[B2_ILW]   = err_ill_wr;
    set2[B2_ILR]   = err_ill_rd;
    set2[B2_RTO]   = err_rsp_to;
    set2[B2_RBRDY] = buf_rise[0];
    set2[B2_WBRDY] = buf_rise[1];
    set2[B2_ILA]   = err_ill_acc;
  end

  sd_flag_bank #(.DATA_W(DATA_W), .KEEP(KEEP1)) u_bank1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set1),
    .hit_i  (hit_sts1),
    .wdata_i(bus_wdata),
    .flags_o(flags1_q)
  );

  sd_flag_bank #(.DATA_W(DATA_W), .KEEP(KEEP2)) u_bank2 (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set2),
    .hit_i  (hit_sts2),
    .wdata_i(bus_wdata),
    .flags_o(flags2_q)
  );

  // Mask words, reset to all-blocked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1_q <= K1;
      mask2_q <= K2;
    end else begin
      if (hit_msk1) mask1_q <= bus_wdata & K1;
      if (hit_msk2) mask2_q <= bus_wdata & K2;
    end
  end

  // Live bits
  always_comb begin
    live1          = '0;
    live1[B1_CDLV] = cd_live;
    live2          = '0;
    live2[B2_DAT0] = dat0_in;
    live2[B2_BUSY] = cmd_busy_in;
  end

  // Read mux
  always_comb begin
    case (bus_addr)
      ADDR_W'(WA_STS1): bus_rdata = flags1_q | live1;
      ADDR_W'(WA_MSK1): bus_rdata = mask1_q;
      ADDR_W'(WA_STS2): bus_rdata = flags2_q | live2;
      default:          bus_rdata = mask2_q;
    endcase
  end

  // Registered interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_open(flags1_q, mask1_q, flags2_q, mask2_q);
  end

  assign irq = irq_q;

endmodule

// File: rtl/sd_irq_regs_chk.sv
module sd_irq_regs_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              dat0_in,
  input logic              cmd_busy_in,
  input logic              rbuf_full,
  input logic              irq,
  input logic [DATA_W-1:0] set1,
  input logic [DATA_W-1:0] set2,
  input logic [DATA_W-1:0] flags1_q,
  input logic [DATA_W-1:0] flags2_q,
  input logic [DATA_W-1:0] mask1_q,
  input logic [DATA_W-1:0] mask2_q
);
  import sd_irq_pkg::*;

  logic [DATA_W-1:0] zero_clr1;
  assign zero_clr1 = (bus_wr && bus_addr == ADDR_W'(WA_STS1)) ? ~bus_wdata : '0;

  // R2: an event always lands in its flag
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set1) |=> ((flags1_q & $past(set1)) == $past(set1)));

  // R4: set wins against a clearing write on word 2
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(WA_STS2) && (|set2))
      |=> ((flags2_q & $past(set2)) == $past(set2)));

  // R3: a flag falls only where a zero was written
  a_r3_drop_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags1_q) & ~flags1_q) & ~$past(zero_clr1)) == '0));

  // R9: registered interrupt follows pending-and-open flags
  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(any_open(flags1_q, mask1_q, flags2_q, mask2_q))));

  // R6: live bits show the inputs
  a_r6_live_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(WA_STS2)) |->
      (bus_rdata[B2_DAT0] == dat0_in && bus_rdata[B2_BUSY] == cmd_busy_in));

  // R5: a held buffer-full level does not set the flag again
  a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rbuf_full && $past(rbuf_full) && !flags2_q[B2_RBRDY])
      |=> !flags2_q[B2_RBRDY]);

endmodule

bind sd_irq_regs sd_irq_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .dat0_in    (dat0_in),
  .cmd_busy_in(cmd_busy_in),
  .rbuf_full  (rbuf_full),
  .irq        (irq),
  .set1       (set1),
  .set2       (set2),
  .flags1_q   (flags1_q),
  .flags2_q   (flags2_q),
  .mask1_q    (mask1_q),
  .mask2_q    (mask2_q)
);

// File: tb/sd_irq_regs_test.sv
`timescale 1ns/1ps
module sd_irq_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        ev_resp_done = 0, ev_data_done = 0;
  logic        err_cmd_idx = 0, err_crc = 0, err_end_bit = 0, err_data_to = 0;
  logic        err_ill_wr = 0, err_ill_rd = 0, err_rsp_to = 0, err_ill_acc = 0;
  logic        rbuf_full = 0, wbuf_empty = 0, cd_pin = 0, dat0_in = 0, cmd_busy_in = 0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  sd_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_resp_done(ev_resp_done), .ev_data_done(ev_data_done),
    .err_cmd_idx(err_cmd_idx), .err_crc(err_crc), .err_end_bit(err_end_bit),
    .err_data_to(err_data_to), .err_ill_wr(err_ill_wr), .err_ill_rd(err_ill_rd),
    .err_rsp_to(err_rsp_to), .err_ill_acc(err_ill_acc),
    .rbuf_full(rbuf_full), .wbuf_empty(wbuf_empty), .cd_pin(cd_pin),
    .dat0_in(dat0_in), .cmd_busy_in(cmd_busy_in), .irq(irq)
  );

  // {events[9:0], wr, addr[1:0], wdata[31:0], exp_sts1[15:0], exp_sts2[15:0]}
  // events: 0 resp,1 data,2 idx,3 crc,4 endbit,5 dto,6 ilw,7 ilr,8 rto,9 ila
  localparam int NV = 12;
  localparam logic [76:0] VEC [NV] = '{
    {10'h001, 1'b0, 2'd0, 32'h00000000, 16'h0001, 16'h0000},
    {10'h108, 1'b0, 2'd0, 32'h00000000, 16'h0001, 16'h0042},
    {10'h000, 1'b1, 2'd0, 32'hFFFFFFFE, 16'h0000, 16'h0042},
    {10'h202, 1'b0, 2'd0, 32'h00000000, 16'h0004, 16'h8042},
    {10'h000, 1'b1, 2'd2, 32'hFFFFFFFD, 16'h0004, 16'h8040},
    {10'h001, 1'b1, 2'd0, 32'h00000000, 16'h0001, 16'h8040},
    {10'h004, 1'b1, 2'd2, 32'h00000000, 16'h0001, 16'h0001},
    {10'h0F0, 1'b0, 2'd0, 32'h00000000, 16'h0001, 16'h003D},
    {10'h000, 1'b1, 2'd0, 32'hFFFFFFFF, 16'h0001, 16'h003D},
    {10'h000, 1'b1, 2'd2, 32'h0000FFF0, 16'h0001, 16'h0030},
    {10'h000, 1'b1, 2'd0, 32'h00000000, 16'h0000, 16'h0030},
    {10'h000, 1'b1, 2'd2, 32'h00000000, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.25;
    v = bus_rdata;
  endtask

  task automatic set_events(input logic [9:0] e);
    {err_ill_acc, err_rsp_to, err_ill_rd, err_ill_wr, err_data_to,
     err_end_bit, err_crc, err_cmd_idx, ev_data_done, ev_resp_done} = e;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    rd(2'd0, v); chk("R1 sts1", v, 32'h0);
    rd(2'd2, v); chk("R1 sts2", v, 32'h0);
    rd(2'd1, v); chk("R1 msk1", v, 32'h0000001D);
    rd(2'd3, v); chk("R1 msk2", v, 32'h0000837F);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 R3 R4: vector walk
    for (int i = 0; i < NV; i++) begin
      set_events(VEC[i][76:67]);
      bus_wr = VEC[i][66]; bus_addr = VEC[i][65:64]; bus_wdata = VEC[i][63:32];
      tick(1);
      set_events(10'd0);
      bus_wr = 1'b0;
      rd(2'd0, v); chk($sformatf("R2/R3/R4 vec%0d sts1", i), v, {16'd0, VEC[i][31:16]});
      rd(2'd2, v); chk($sformatf("R2/R3/R4 vec%0d sts2", i), v, {16'd0, VEC[i][15:0]});
    end

    // R5: edge-set read buffer ready, no re-set while held
    rbuf_full = 1'b1;
    tick(1);
    rd(2'd2, v); chk("R5 rbuf rise", v, 32'h00000100);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R5 rbuf cleared", v, 32'h0);
    tick(3);
    rd(2'd2, v); chk("R5 rbuf held no reset", v, 32'h0);
    rbuf_full = 1'b0; tick(1);
    rbuf_full = 1'b1; tick(1);
    rd(2'd2, v); chk("R5 rbuf second rise", v, 32'h00000100);
    wbuf_empty = 1'b1; tick(1);
    rd(2'd2, v); chk("R5 wbuf rise", v, 32'h00000300);
    wr(2'd2, 32'h0);
    tick(2);
    rd(2'd2, v); chk("R5 wbuf held no reset", v, 32'h0);
    rbuf_full = 1'b0; wbuf_empty = 1'b0;

    // R6: live DAT0 and busy, writes ignored
    dat0_in = 1'b1; cmd_busy_in = 1'b1;
    rd(2'd2, v); chk("R6 live dat0/busy", v, 32'h00004080);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R6 live survives write", v, 32'h00004080);
    dat0_in = 1'b0; cmd_busy_in = 1'b0;
    rd(2'd2, v); chk("R6 live follows low", v, 32'h0);

    // R6 R7: card detect sync and edges
    cd_pin = 1'b1;
    tick(1);
    rd(2'd0, v); chk("R6 cd one edge", v, 32'h0);
    tick(1);
    rd(2'd0, v); chk("R6 cd live", v, 32'h00000020);
    tick(1);
    rd(2'd0, v); chk("R7 insert", v, 32'h00000030);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R6 cd live write ignored", v, 32'h00000020);
    cd_pin = 1'b0;
    tick(3);
    rd(2'd0, v); chk("R7 remove", v, 32'h00000008);
    wr(2'd0, 32'h0);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);

    // R8 R10: mask access and unused bits
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R10 msk1 zero", v, 32'h0);
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, v); chk("R10 msk1 ones", v, 32'h0000001D);
    wr(2'd1, 32'hFFFFFFFE);
    rd(2'd1, v); chk("R8 msk1 open bit0", v, 32'h0000001C);

    // R9: one-cycle latency
    ev_resp_done = 1'b1; tick(1); ev_resp_done = 1'b0;
    chk("R9 irq latency 0", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    wr(2'd0, 32'h0);
    chk("R9 irq still 1", {31'd0, irq}, 32'd1);
    tick(1);
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);

    // R8: masked flag stays silent; live bit silent
    ev_data_done = 1'b1; tick(1); ev_data_done = 1'b0;
    dat0_in = 1'b1;
    tick(2);
    chk("R8 masked flag no irq", {31'd0, irq}, 32'd0);
    dat0_in = 1'b0;
    wr(2'd0, 32'h0);

    // R8: word 2 mask
    wr(2'd3, 32'hFFFF7FFF);
    rd(2'd3, v); chk("R8 msk2 open bit15", v, 32'h0000037F);
    err_ill_acc = 1'b1; tick(1); err_ill_acc = 1'b0;
    tick(1);
    chk("R8 word2 irq", {31'd0, irq}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule